// File: doc/BRIEF.md
# Program Counter and Call Stack Unit

This block holds the program counter of a small interpreter-style CPU with sixteen 8-bit registers and 16-bit instructions. It also decides where that counter goes next. Each accepted instruction advances the counter by one instruction (two bytes), except for the control-flow instructions:

- absolute jumps, indexed jumps and subroutine calls replace the counter;
- returns replace the counter with a saved return address;
- conditional skips advance it by two instructions instead of one.

Return addresses are not held in a private stack. They go out to byte-addressed data memory at a pointer that the block keeps. That pointer moves down by two bytes on each call and up by two bytes on each return.

The instruction word drives the block directly. The class sits in the top four bits, the address field in the low twelve bits and the immediate in the low eight bits. The register file supplies three values: the register named by the instruction's first register field, the one named by its second, and register 0. The counter always holds the address of the instruction being executed. Memory answers a read request with its data one cycle later, so a return takes two cycles. During the second cycle the block shows that it is not ready.

Top module: `pc_flow_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, the counter reads 0x200, the stack pointer reads its initial value (0xEFE by default), ready is high and neither memory request is raised.
- R2: An accepted instruction that is not a control-flow instruction sets the counter to counter+2. This includes class 0 words other than 0x00EE.
- R3: An accepted class 1 instruction (top nibble 0x1) loads the counter with the instruction's low 12 bits.
- R4: In the cycle it is accepted, a class 2 instruction raises a write request to the stack pointer address. The write data is counter+2, zero-extended to 16 bits; its high byte belongs at the lower byte address. On the next edge the counter takes the low 12 bits and the stack pointer drops by 2.
- R5: In the cycle it is accepted, the return word 0x00EE raises a read request at stack pointer+2. In the next cycle ready is low, and the counter loads the low 12 bits of the returned 16-bit word. One cycle later ready is high again and the stack pointer is 2 higher.
- R6: An instruction presented while ready is low is ignored. The counter and the stack pointer take only the values that the return sets.
- R7: Class 3 sets counter+4 when the first register equals the low byte, otherwise counter+2. Class 4 does the opposite.
- R8: Class 5 with low nibble 0 sets counter+4 when the two registers are equal, otherwise counter+2. Class 9 with low nibble 0 does the opposite. With a nonzero low nibble, either class only advances by 2.
- R9: An accepted class 0xB instruction sets the counter to the low 12 bits plus the unsigned register 0 value, modulo 4096.
- R10: All counter arithmetic wraps modulo 4096.
- R11: With the step input low and ready high, the counter and the stack pointer hold and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Execute the instruction on instr_i this cycle |
| instr_i | input | 16 | Instruction word |
| vx_i | input | 8 | Value of the first named register |
| vy_i | input | 8 | Value of the second named register |
| v0_i | input | 8 | Value of register 0 |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| pc_o | output | 12 | Address of the current instruction |
| sp_o | output | 12 | Return-stack pointer |
| ready_o | output | 1 | Low while a return waits for its data |
| mem_we_o | output | 1 | Write request |
| mem_re_o | output | 1 | Read request |
| mem_addr_o | output | 12 | Byte address of the request |
| mem_wdata_o | output | 16 | Write data |

## Verification
Two things can fall in the same cycle: a return that completes from memory data, and a new instruction on the step input. The bench provokes this by holding the step input high with a jump, or with a second return, during the wait cycle. It judges the result on the counter and the pointer, which must take the memory value and the +2 adjustment only. Nested calls followed by returns check that writes and reads address the same slots. A return with no earlier call reads a preloaded word whose top nibble is set, which shows that only 12 bits are loaded.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

   typedef enum logic [3:0] {
      K_ADV,
      K_JMP,
      K_CALL,
      K_RET,
      K_SKIP_IMM_EQ,
      K_SKIP_IMM_NE,
      K_SKIP_REG_EQ,
      K_SKIP_REG_NE,
      K_JIDX
   } flow_kind_e;

   typedef enum logic {
      ST_RUN,
      ST_RETWAIT
   } pcu_state_e;

   function automatic logic is_skip(flow_kind_e k);
      return (k == K_SKIP_IMM_EQ) || (k == K_SKIP_IMM_NE) ||
             (k == K_SKIP_REG_EQ) || (k == K_SKIP_REG_NE);
   endfunction

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
   import pcu_pkg::*;
#(
   parameter int unsigned INSTR_W         = 16,
   parameter bit          STRICT_REG_SKIP = 1'b1
) (
   input  logic [INSTR_W-1:0] instr_i,
   output flow_kind_e         kind_o
);

   localparam logic [INSTR_W-1:0] RET_WORD = INSTR_W'(16'h00EE);

   logic [3:0] opclass;
   logic       reg_form_ok;

   assign opclass = instr_i[INSTR_W-1 -: 4];

   generate
      if (STRICT_REG_SKIP) begin : g_strict
         assign reg_form_ok = (instr_i[3:0] == 4'h0);
      end else begin : g_loose
         assign reg_form_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      case (opclass)
         4'h0:    kind_o = (instr_i == RET_WORD) ? K_RET : K_ADV;
         4'h1:    kind_o = K_JMP;
         4'h2:    kind_o = K_CALL;
         4'h3:    kind_o = K_SKIP_IMM_EQ;
         4'h4:    kind_o = K_SKIP_IMM_NE;
         4'h5:    kind_o = reg_form_ok ? K_SKIP_REG_EQ : K_ADV;
         4'h9:    kind_o = reg_form_ok ? K_SKIP_REG_NE : K_ADV;
         4'hB:    kind_o = K_JIDX;
         default: kind_o = K_ADV;
      endcase
   end

endmodule

// File: rtl/pcu_skip_eval.sv
module pcu_skip_eval
   import pcu_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  flow_kind_e        kind_i,
   input  logic [DATA_W-1:0] vx_i,
   input  logic [DATA_W-1:0] vy_i,
   input  logic [DATA_W-1:0] imm_i,
   output logic              take_o
);

   logic eq_imm;
   logic eq_reg;

   assign eq_imm = (vx_i == imm_i);
   assign eq_reg = (vx_i == vy_i);

   always_comb begin
      case (kind_i)
         K_SKIP_IMM_EQ: take_o = eq_imm;
         K_SKIP_IMM_NE: take_o = !eq_imm;
         K_SKIP_REG_EQ: take_o = eq_reg;
         K_SKIP_REG_NE: take_o = !eq_reg;
         default:       take_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/pcu_stack_ptr.sv
module pcu_stack_ptr #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned SP_INIT = 'hEFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   output logic [ADDR_W-1:0] sp_o,
   output logic [ADDR_W-1:0] slot_o
);

   localparam logic [ADDR_W-1:0] SLOT  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] SP_RV = ADDR_W'(SP_INIT);

   logic [ADDR_W-1:0] sp_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      sp_q <= SP_RV;
      else if (push_i) sp_q <= sp_q - SLOT;
      else if (pop_i)  sp_q <= sp_q + SLOT;
   end

   assign sp_o   = sp_q;
   assign slot_o = sp_q + SLOT;

   // R4/R5: a call and a return completion are never requested together
   p_push_pop_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));

   // R5: a completed return moves the pointer up by exactly one slot
   p_pop_moves_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> (sp_o == $past(slot_o)));

endmodule

// File: rtl/pc_flow_unit.sv
module pc_flow_unit
   import pcu_pkg::*;
#(
   parameter int unsigned ADDR_W          = 12,
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned WORD_W          = 16,
   parameter int unsigned INSTR_W         = 16,
   parameter int unsigned RESET_PC        = 'h200,
   parameter int unsigned SP_INIT         = 'hEFE,
   parameter bit          STRICT_REG_SKIP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  vx_i,
   input  logic [DATA_W-1:0]  vy_i,
   input  logic [DATA_W-1:0]  v0_i,
   input  logic [WORD_W-1:0]  mem_rdata_i,
   output logic [ADDR_W-1:0]  pc_o,
   output logic [ADDR_W-1:0]  sp_o,
   output logic               ready_o,
   output logic               mem_we_o,
   output logic               mem_re_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   output logic [WORD_W-1:0]  mem_wdata_o
);

   localparam logic [ADDR_W-1:0] ONE_INSTR = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] TWO_INSTR = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] PC_RV     = ADDR_W'(RESET_PC);

   // elaboration-time parameter checks
   generate
      if (INSTR_W != ADDR_W + 4) begin : g_bad_instr_w
         $error("instruction width must equal address width plus a 4-bit class");
      end
      if (DATA_W > ADDR_W) begin : g_bad_data_w
         $error("register width may not exceed address width");
      end
      if (ADDR_W > WORD_W) begin : g_bad_word_w
         $error("a return address must fit in one memory word");
      end
      if ((RESET_PC % 2) != 0 || (SP_INIT % 2) != 0) begin : g_bad_align
         $error("reset counter and stack pointer must be even");
      end
   endgenerate

   flow_kind_e        kind;
   pcu_state_e        state_q, state_d;
   logic              take_skip;
   logic              accept;
   logic              push, pop;
   logic [ADDR_W-1:0] pc_q, pc_d;
   logic [ADDR_W-1:0] sp, slot;
   logic [ADDR_W-1:0] pc_seq, pc_skip, field, jidx_tgt;
   logic              unused_rdata_hi;

   assign unused_rdata_hi = ^mem_rdata_i[WORD_W-1:ADDR_W];

   pcu_decode #(
      .INSTR_W        (INSTR_W),
      .STRICT_REG_SKIP(STRICT_REG_SKIP)
   ) u_decode (
      .instr_i(instr_i),
      .kind_o (kind)
   );

   pcu_skip_eval #(
      .DATA_W(DATA_W)
   ) u_skip (
      .kind_i(kind),
      .vx_i  (vx_i),
      .vy_i  (vy_i),
      .imm_i (instr_i[DATA_W-1:0]),
      .take_o(take_skip)
   );

   pcu_stack_ptr #(
      .ADDR_W (ADDR_W),
      .SP_INIT(SP_INIT)
   ) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .push_i(push),
      .pop_i (pop),
      .sp_o  (sp),
      .slot_o(slot)
   );

   assign field    = instr_i[ADDR_W-1:0];
   assign pc_seq   = pc_q + ONE_INSTR;
   assign pc_skip  = pc_q + TWO_INSTR;
   assign jidx_tgt = field + ADDR_W'(v0_i);
   assign accept   = step_i && (state_q == ST_RUN);

   always_comb begin
      pc_d        = pc_q;
      state_d     = state_q;
      push        = 1'b0;
      pop         = 1'b0;
      mem_we_o    = 1'b0;
      mem_re_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      if (state_q == ST_RETWAIT) begin
         pc_d    = mem_rdata_i[ADDR_W-1:0];
         pop     = 1'b1;
         state_d = ST_RUN;
      end else if (step_i) begin
         case (kind)
            K_JMP:  pc_d = field;
            K_JIDX: pc_d = jidx_tgt;
            K_CALL: begin
               pc_d        = field;
               push        = 1'b1;
               mem_we_o    = 1'b1;
               mem_addr_o  = sp;
               mem_wdata_o = WORD_W'(pc_seq);
            end
            K_RET: begin
               mem_re_o   = 1'b1;
               mem_addr_o = slot;
               state_d    = ST_RETWAIT;
            end
            K_SKIP_IMM_EQ, K_SKIP_IMM_NE, K_SKIP_REG_EQ, K_SKIP_REG_NE:
               pc_d = take_skip ? pc_skip : pc_seq;
            default: pc_d = pc_seq;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= PC_RV;
         state_q <= ST_RUN;
      end else begin
         pc_q    <= pc_d;
         state_q <= state_d;
      end
   end

   assign pc_o    = pc_q;
   assign sp_o    = sp;
   assign ready_o = (state_q == ST_RUN);

   // R1: reset puts the counter at the code start and the unit ready
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (pc_o == PC_RV && ready_o && !mem_we_o && !mem_re_o));

   // R5: never a read and a write in one cycle
   p_one_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o));

   // R5: an accepted return leaves the unit not ready for one cycle
   p_ret_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == K_RET) |=> !ready_o);

   // R5/R6: the wait cycle loads the counter from memory only, then ready returns
   p_ret_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |=> (ready_o && pc_o == $past(mem_rdata_i[ADDR_W-1:0])));

   // R4: a call writes to the current pointer and moves the pointer down
   p_call_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> (sp_o == $past(mem_addr_o) - ONE_INSTR));

   // R7: a skip moves the counter by one or two instructions
   p_skip_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_skip(kind)) |=>
         (pc_o == $past(pc_o) + ONE_INSTR || pc_o == $past(pc_o) + TWO_INSTR));

   // R11: no step while ready leaves everything still
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && ready_o) |=> ($stable(pc_o) && $stable(sp_o)));

endmodule

// File: tb/sim_pc_flow_unit.sv
module sim_pc_flow_unit;

   localparam int CLK_PERIOD = 10;
   localparam int SP0        = 'hEFE;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        step_i;
   logic [15:0] instr_i;
   logic [7:0]  vx_i, vy_i, v0_i;
   logic [15:0] mem_rdata_i;
   logic [11:0] pc_o, sp_o, mem_addr_o;
   logic        ready_o, mem_we_o, mem_re_o;
   logic [15:0] mem_wdata_o;

   int total = 0;
   int bad   = 0;

   // environment memory (bytes) and the model's own copy
   logic [7:0] env_mem [int];
   logic [7:0] mdl_mem [int];

   int m_pc, m_sp, m_wait;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_flow_unit u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step_i),
      .instr_i    (instr_i),
      .vx_i       (vx_i),
      .vy_i       (vy_i),
      .v0_i       (v0_i),
      .mem_rdata_i(mem_rdata_i),
      .pc_o       (pc_o),
      .sp_o       (sp_o),
      .ready_o    (ready_o),
      .mem_we_o   (mem_we_o),
      .mem_re_o   (mem_re_o),
      .mem_addr_o (mem_addr_o),
      .mem_wdata_o(mem_wdata_o)
   );

   function automatic logic [7:0] env_rd(int a);
      return env_mem.exists(a & 'hFFF) ? env_mem[a & 'hFFF] : 8'h00;
   endfunction

   function automatic logic [7:0] mdl_rd(int a);
      return mdl_mem.exists(a & 'hFFF) ? mdl_mem[a & 'hFFF] : 8'h00;
   endfunction

   always @(posedge clk) begin
      if (mem_we_o) begin
         env_mem[int'(mem_addr_o)]              = mem_wdata_o[15:8];
         env_mem[(int'(mem_addr_o) + 1) & 'hFFF] = mem_wdata_o[7:0];
      end
      if (mem_re_o)
         mem_rdata_i <= {env_rd(int'(mem_addr_o)), env_rd(int'(mem_addr_o) + 1)};
   end

   task automatic check(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive, compare everything with the model, then advance the model
   task automatic cyc(string tag, logic st, logic [15:0] ins,
                      logic [7:0] x = 0, logic [7:0] y = 0, logic [7:0] z = 0);
      int cls, fld, e_we, e_re, e_addr, e_wd, nxt;
      @(negedge clk);
      step_i = st; instr_i = ins; vx_i = x; vy_i = y; v0_i = z;
      #1;
      cls = int'(ins[15:12]);
      fld = int'(ins[11:0]);
      e_we = 0; e_re = 0; e_addr = 0; e_wd = 0;
      nxt = m_pc;
      if (m_wait == 0 && st) begin
         nxt = (m_pc + 2) & 'hFFF;
         if (ins == 16'h00EE) begin
            e_re = 1; e_addr = (m_sp + 2) & 'hFFF;
         end else if (cls == 1) nxt = fld;
         else if (cls == 2) begin
            e_we = 1; e_addr = m_sp; e_wd = (m_pc + 2) & 'hFFF; nxt = fld;
         end else if (cls == 3 && x == ins[7:0]) nxt = (m_pc + 4) & 'hFFF;
         else if (cls == 4 && x != ins[7:0]) nxt = (m_pc + 4) & 'hFFF;
         else if (cls == 5 && ins[3:0] == 0 && x == y) nxt = (m_pc + 4) & 'hFFF;
         else if (cls == 9 && ins[3:0] == 0 && x != y) nxt = (m_pc + 4) & 'hFFF;
         else if (cls == 'hB) nxt = (fld + int'(z)) & 'hFFF;
      end
      check(tag, "pc", int'(pc_o), m_pc);
      check(tag, "sp", int'(sp_o), m_sp);
      check(tag, "ready", int'(ready_o), (m_wait == 0) ? 1 : 0);
      check(tag, "we", int'(mem_we_o), e_we);
      check(tag, "re", int'(mem_re_o), e_re);
      if (e_we || e_re) check(tag, "addr", int'(mem_addr_o), e_addr);
      if (e_we) check(tag, "wdata", int'(mem_wdata_o), e_wd);
      if (m_wait != 0) begin
         m_pc   = ((int'(mdl_rd(m_sp + 2)) << 8) | int'(mdl_rd(m_sp + 3))) & 'hFFF;
         m_sp   = (m_sp + 2) & 'hFFF;
         m_wait = 0;
      end else if (e_re) begin
         m_wait = 1;
      end else begin
         if (e_we) begin
            mdl_mem[m_sp]                 = 8'(e_wd >> 8);
            mdl_mem[(m_sp + 1) & 'hFFF]   = 8'(e_wd);
            m_sp = (m_sp - 2) & 'hFFF;
         end
         m_pc = nxt;
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; step_i = 1'b0; instr_i = '0;
      vx_i = '0; vy_i = '0; v0_i = '0; mem_rdata_i = '0;
      // preloaded return word above the initial pointer; top nibble set
      env_mem[SP0 + 2] = 8'hFA; env_mem[SP0 + 3] = 8'hBC;
      mdl_mem[SP0 + 2] = 8'hFA; mdl_mem[SP0 + 3] = 8'hBC;
      m_pc = 'h200; m_sp = SP0; m_wait = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 while reset still held
      check("R1", "pc", int'(pc_o), 'h200);
      check("R1", "sp", int'(sp_o), SP0);
      check("R1", "ready", int'(ready_o), 1);
      check("R1", "req", int'(mem_we_o | mem_re_o), 0);
      rst_n = 1'b1;
      cyc("R1", 1'b0, 16'h0000);
      cyc("R11", 1'b0, 16'h1ABC);
      cyc("R2", 1'b1, 16'h6123);
      cyc("R2", 1'b1, 16'h0123);
      cyc("R3", 1'b1, 16'h1456);
      cyc("R4", 1'b1, 16'h2800);
      cyc("R4", 1'b1, 16'h2900);
      cyc("R11", 1'b0, 16'h2A00);
      cyc("R5", 1'b1, 16'h00EE);
      cyc("R6", 1'b1, 16'h1111);          // step during the wait cycle
      cyc("R5", 1'b1, 16'h00EE);
      cyc("R6", 1'b1, 16'h00EE);          // second return offered while waiting
      cyc("R5", 1'b1, 16'h00EE);          // reads the preloaded word
      cyc("R5", 1'b0, 16'h0000);
      cyc("R7", 1'b1, 16'h3355, 8'h55);
      cyc("R7", 1'b1, 16'h3355, 8'h54);
      cyc("R7", 1'b1, 16'h4A10, 8'h10);
      cyc("R7", 1'b1, 16'h4A10, 8'h11);
      cyc("R8", 1'b1, 16'h5120, 8'h77, 8'h77);
      cyc("R8", 1'b1, 16'h5120, 8'h77, 8'h78);
      cyc("R8", 1'b1, 16'h9120, 8'h01, 8'h02);
      cyc("R8", 1'b1, 16'h9120, 8'h03, 8'h03);
      cyc("R8", 1'b1, 16'h5121, 8'h44, 8'h44);
      cyc("R8", 1'b1, 16'h9123, 8'h01, 8'h02);
      cyc("R9", 1'b1, 16'hB300, 8'h00, 8'h00, 8'h2C);
      cyc("R9", 1'b1, 16'hBF80, 8'h00, 8'h00, 8'hFF);
      cyc("R10", 1'b1, 16'h1FFE);
      cyc("R10", 1'b1, 16'h8012);
      cyc("R10", 1'b1, 16'h1FFC);
      cyc("R10", 1'b1, 16'h3009, 8'h09);
      cyc("R4", 1'b1, 16'h2FFE);
      cyc("R10", 1'b1, 16'h2F00);         // call at 0xFFE pushes 0x000
      cyc("R5", 1'b1, 16'h00EE);
      cyc("R5", 1'b0, 16'h0000);
      cyc("R5", 1'b1, 16'h00EE);
      cyc("R5", 1'b0, 16'h0000);
      cyc("R11", 1'b0, 16'h2123);
      cyc("R11", 1'b0, 16'h00EE);
      cyc("R2", 1'b1, 16'hE09E);
      finish_run();
   end

endmodule